// File: doc/BRIEF.md
# Buffered Flash Program Sequencer

This block is a host-side controller that programs a burst of 1 to 32 words into a parallel NOR-style flash through the flash's buffered-write command sequence. The host gives a request: a block address, a start address and a word count N, where N = 0 means one word. The data words then arrive on a ready/valid stream. The controller drives a simple parallel bus made of an address, write data, a write strobe and a read strobe. It reads status back on a read-data input.

For each request the controller sends the buffer-program command and polls the buffer-availability bit, giving up after a time-out. It then writes the count and the data words, sends the confirm command and polls the ready bit until the flash finishes. If a data address would leave the block, the burst is cut short, the flash status is cleared and the sequence is reported as improper. Every sequence ends by returning the flash to read-array mode. A one-cycle done pulse then reports the result on two flags.

Top module: `flash_bufprog_seq`

## Requirements
- R1: While reset is asserted, busy, done, wr_ready, bus_we and bus_re are all low.
- R2: A sequence starts with a write of 0x00E8 to the block address, followed by a read at the block address. While bit 7 of that read is 0, the write of 0x00E8 and the read are repeated.
- R3: If bit 7 is still 0 when a poll is evaluated and at least TMO_CYCLES cycles of polling have passed since the start, no count is written. The controller writes 0x00FF to the block address and raises done with timed_out = 1 and seq_error = 0.
- R4: Once bit 7 reads 1, the count N is written, zero-extended, to the block address. N = 0 stands for one word, and N covers 0 to 31.
- R5: The controller takes N+1 words from the stream in order and writes word i to start_addr + i. It takes no stream word outside the data phase.
- R6: After the last data word, the controller writes 0x00D0 to the block address.
- R7: After the confirm, the controller reads the block address until bit 7 is 1. It then writes 0x00FF to the block address and raises done with both flags at 0.
- R8: Two addresses are in the same block when their bits [AW-1:BLK_BITS] are equal. If the next data address falls outside block_addr's block, that write is not issued and the stream word is not taken. The controller then writes 0x0050 and then 0x00FF to the block address and raises done with seq_error = 1 and timed_out = 0.
- R9: Each write holds bus_addr and bus_wdata stable while bus_we is high, and bus_we stays high for exactly WE_WIDTH cycles. bus_we and bus_re are never high together.
- R10: busy rises in the cycle after an accepted start and stays high until the done pulse. done lasts one cycle. A start pulse that arrives while busy has no effect on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken only when idle |
| block_addr | input | AW | Address used for commands and status reads |
| start_addr | input | AW | Address of the first data word |
| word_count | input | CNT_W | Word count minus one |
| wr_data | input | DW | Stream data word |
| wr_valid | input | 1 | Stream word valid |
| wr_ready | output | 1 | Stream word accepted when high with wr_valid |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| timed_out | output | 1 | Availability poll timed out; valid with done |
| seq_error | output | 1 | Burst left the block; valid with done |
| bus_addr | output | AW | Flash bus address |
| bus_wdata | output | DW | Flash bus write data |
| bus_we | output | 1 | Flash write strobe |
| bus_re | output | 1 | Flash read strobe |
| bus_rdata | input | DW | Flash bus read data |

## Verification
A wrong state in the sequencer shows up at the bus on the next write strobe. That write has the wrong command code, the wrong address or the wrong data, so a cycle-by-cycle log of the write strobes, compared with the sequence computed from the request, finds it within one bus operation. A fault in the word counter or the block check shows up as a wrong number of data writes, a wrong number of stream words taken, or a wrong error flag at the done pulse. Faults in the strobe timing are caught by measuring each write-strobe pulse and checking that the address stays fixed while the strobe is high.

// File: rtl/bufprog_pkg.sv
package bufprog_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CMD,
    S_XSR,
    S_CNT,
    S_DATA,
    S_CONF,
    S_SR,
    S_CLR,
    S_RESET,
    S_DONE
  } seq_state_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_PULSE,
    PH_HOLD,
    PH_READ,
    PH_ACK
  } bus_phase_t;

  localparam logic [7:0] CMD_BUF_PGM    = 8'hE8;
  localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
  localparam logic [7:0] CMD_CLR_STAT   = 8'h50;
  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
  localparam int         READY_BIT      = 7;

endpackage

// File: rtl/bufprog_bus.sv
module bufprog_bus
  import bufprog_pkg::*;
#(
  parameter int AW       = 12,
  parameter int DW       = 16,
  parameter int WE_SETUP = 1,
  parameter int WE_WIDTH = 2,
  parameter int WE_HOLD  = 1,
  parameter int RD_LAT   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          ack,
  output logic          rd_ready,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_we,
  output logic          bus_re,
  input  logic [DW-1:0] bus_rdata
);

  localparam int M1   = (WE_SETUP > WE_WIDTH) ? WE_SETUP : WE_WIDTH;
  localparam int M2   = (M1 > WE_HOLD) ? M1 : WE_HOLD;
  localparam int MAXP = (M2 > RD_LAT) ? M2 : RD_LAT;
  localparam int CW   = $clog2(MAXP + 1);
  localparam logic [CW-1:0] L_SETUP = CW'(WE_SETUP - 1);
  localparam logic [CW-1:0] L_PULSE = CW'(WE_WIDTH - 1);
  localparam logic [CW-1:0] L_HOLD  = CW'(WE_HOLD - 1);
  localparam logic [CW-1:0] L_READ  = CW'(RD_LAT - 1);

  bus_phase_t    phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] len_m1;
  logic          last;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          rdy_q, rdy_d;
  logic          cap_en;

  always_comb begin
    unique case (phase_q)
      PH_SETUP: len_m1 = L_SETUP;
      PH_PULSE: len_m1 = L_PULSE;
      PH_HOLD:  len_m1 = L_HOLD;
      PH_READ:  len_m1 = L_READ;
      default:  len_m1 = '0;
    endcase
  end

  assign last   = (cnt_q == len_m1);
  assign cap_en = (phase_q == PH_IDLE) && req;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    rdy_d   = rdy_q;
    unique case (phase_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (req) phase_d = req_wr ? PH_SETUP : PH_READ;
      end
      PH_SETUP, PH_PULSE, PH_HOLD: begin
        if (last) begin
          cnt_d = '0;
          if (phase_q == PH_SETUP)      phase_d = PH_PULSE;
          else if (phase_q == PH_PULSE) phase_d = PH_HOLD;
          else                          phase_d = PH_ACK;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_READ: begin
        if (last) begin
          cnt_d   = '0;
          rdy_d   = bus_rdata[READY_BIT];
          phase_d = PH_ACK;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_ACK:  phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      rdy_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      rdy_q   <= rdy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (cap_en) begin
      addr_q <= req_addr;
      data_q <= req_data;
    end
  end

  assign ack       = (phase_q == PH_ACK);
  assign rd_ready  = rdy_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = data_q;
  assign bus_we    = (phase_q == PH_PULSE);
  assign bus_re    = (phase_q == PH_READ);

  AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re)); // R9
  AST_REQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (phase_q == PH_IDLE)); // R9
  AST_RDATA_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && last) |-> !$isunknown(bus_rdata)); // R7

endmodule

// File: rtl/bufprog_timer.sv
module bufprog_timer #(
  parameter int LIMIT = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic expired
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;

  assign expired = (cnt_q == LIM);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                 cnt_d = '0;
    else if (en && !expired) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TMR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !clr) |=> expired); // R3

endmodule

// File: rtl/bufprog_addr.sv
module bufprog_addr #(
  parameter int AW       = 12,
  parameter int BLK_BITS = 5,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [AW-1:0]    blk_in,
  input  logic [AW-1:0]    start_in,
  input  logic [CNT_W-1:0] n_in,
  output logic [AW-1:0]    cur_addr,
  output logic [CNT_W-1:0] n_out,
  output logic             in_block,
  output logic             last
);

  localparam int TW = AW - BLK_BITS;

  logic [TW-1:0]    tag_q;
  logic [AW-1:0]    cur_q, cur_d;
  logic [CNT_W-1:0] x_q, x_d;
  logic [CNT_W-1:0] n_q;

  always_comb begin
    cur_d = cur_q;
    x_d   = x_q;
    if (load) begin
      cur_d = start_in;
      x_d   = '0;
    end else if (step) begin
      cur_d = cur_q + 1'b1;
      x_d   = x_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      x_q   <= '0;
    end else begin
      cur_q <= cur_d;
      x_q   <= x_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      n_q   <= '0;
    end else if (load) begin
      tag_q <= blk_in[AW-1:BLK_BITS];
      n_q   <= n_in;
    end
  end

  assign cur_addr = cur_q;
  assign n_out    = n_q;
  assign in_block = (cur_q[AW-1:BLK_BITS] == tag_q);
  assign last     = (x_q == n_q);

  AST_STEP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |-> !last); // R5

endmodule

// File: rtl/flash_bufprog_seq.sv
module flash_bufprog_seq
  import bufprog_pkg::*;
#(
  parameter int AW         = 12,
  parameter int DW         = 16,
  parameter int BLK_BITS   = 5,
  parameter int CNT_W      = 5,
  parameter int WE_SETUP   = 1,
  parameter int WE_WIDTH   = 2,
  parameter int WE_HOLD    = 1,
  parameter int RD_LAT     = 2,
  parameter int TMO_CYCLES = 300
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    block_addr,
  input  logic [AW-1:0]    start_addr,
  input  logic [CNT_W-1:0] word_count,
  input  logic [DW-1:0]    wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic             busy,
  output logic             done,
  output logic             timed_out,
  output logic             seq_error,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  output logic             bus_we,
  output logic             bus_re,
  input  logic [DW-1:0]    bus_rdata
);

  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  seq_state_t       state_q, state_d;
  logic             pend_q, pend_d;
  logic [AW-1:0]    blk_q;
  logic             tmo_q, err_q;
  logic             op_req, op_wr;
  logic [AW-1:0]    op_addr;
  logic [DW-1:0]    op_data;
  logic             ack, rd_ready;
  logic             load, step, tmr_clr, tmr_en, expired;
  logic             set_tmo, set_err;
  logic [AW-1:0]    cur_addr;
  logic [CNT_W-1:0] n_val;
  logic             in_block, last;

  bufprog_bus #(
    .AW(AW), .DW(DW), .WE_SETUP(WE_SETUP), .WE_WIDTH(WE_WIDTH),
    .WE_HOLD(WE_HOLD), .RD_LAT(RD_LAT)
  ) u_bus (
    .clk(clk), .rst_n(rst_n_i),
    .req(op_req), .req_wr(op_wr), .req_addr(op_addr), .req_data(op_data),
    .ack(ack), .rd_ready(rd_ready),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata)
  );

  bufprog_timer #(.LIMIT(TMO_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n_i), .clr(tmr_clr), .en(tmr_en), .expired(expired)
  );

  bufprog_addr #(.AW(AW), .BLK_BITS(BLK_BITS), .CNT_W(CNT_W)) u_addr (
    .clk(clk), .rst_n(rst_n_i), .load(load), .step(step),
    .blk_in(block_addr), .start_in(start_addr), .n_in(word_count),
    .cur_addr(cur_addr), .n_out(n_val), .in_block(in_block), .last(last)
  );

  assign tmr_en = (state_q == S_CMD) || (state_q == S_XSR);

  always_comb begin
    state_d  = state_q;
    op_req   = 1'b0;
    op_wr    = 1'b1;
    op_addr  = blk_q;
    op_data  = '0;
    wr_ready = 1'b0;
    step     = 1'b0;
    load     = 1'b0;
    tmr_clr  = 1'b0;
    set_tmo  = 1'b0;
    set_err  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          load    = 1'b1;
          tmr_clr = 1'b1;
          state_d = S_CMD;
        end
      end
      S_CMD: begin
        op_req  = !pend_q;
        op_data = DW'(CMD_BUF_PGM);
        if (ack) state_d = S_XSR;
      end
      S_XSR: begin
        op_req = !pend_q;
        op_wr  = 1'b0;
        if (ack) begin
          if (rd_ready) begin
            state_d = S_CNT;
          end else if (expired) begin
            set_tmo = 1'b1;
            state_d = S_RESET;
          end else begin
            state_d = S_CMD;
          end
        end
      end
      S_CNT: begin
        op_req  = !pend_q;
        op_data = DW'(n_val);
        if (ack) state_d = S_DATA;
      end
      S_DATA: begin
        op_addr = cur_addr;
        op_data = wr_data;
        if (!pend_q) begin
          if (!in_block) begin
            set_err = 1'b1;
            state_d = S_CLR;
          end else begin
            wr_ready = 1'b1;
            op_req   = wr_valid;
          end
        end
        if (ack) begin
          if (last) state_d = S_CONF;
          else      step    = 1'b1;
        end
      end
      S_CONF: begin
        op_req  = !pend_q;
        op_data = DW'(CMD_CONFIRM);
        if (ack) state_d = S_SR;
      end
      S_SR: begin
        op_req = !pend_q;
        op_wr  = 1'b0;
        if (ack && rd_ready) state_d = S_RESET;
      end
      S_CLR: begin
        op_req  = !pend_q;
        op_data = DW'(CMD_CLR_STAT);
        if (ack) state_d = S_RESET;
      end
      S_RESET: begin
        op_req  = !pend_q;
        op_data = DW'(CMD_READ_ARRAY);
        if (ack) state_d = S_DONE;
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    pend_d = pend_q;
    if (ack)         pend_d = 1'b0;
    else if (op_req) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= S_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)  blk_q <= '0;
    else if (load) blk_q <= block_addr;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      tmo_q <= 1'b0;
      err_q <= 1'b0;
    end else if (load) begin
      tmo_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (set_tmo) tmo_q <= 1'b1;
      if (set_err) err_q <= 1'b1;
    end
  end

  assign busy      = (state_q != S_IDLE);
  assign done      = (state_q == S_DONE);
  assign timed_out = tmo_q;
  assign seq_error = err_q;

  AST_DATA_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n_i)
    (bus_we && state_q == S_DATA) |-> (bus_addr[AW-1:BLK_BITS] == blk_q[AW-1:BLK_BITS])); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n_i)
    done |=> !done); // R10
  AST_WREADY_BUSY: assert property (@(posedge clk) disable iff (!rst_n_i)
    wr_ready |-> busy); // R5
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n_i)
    done |-> !(timed_out && seq_error)); // R3

endmodule

// File: tb/flash_bufprog_seq_tb_top.sv
module flash_bufprog_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 12;
  localparam int DW   = 16;
  localparam int BB   = 5;
  localparam int CW   = 5;
  localparam int WEW  = 2;
  localparam int TMO  = 300;
  localparam int LOGN = 256;

  logic          clk, rst_n, start;
  logic [AW-1:0] blk_in, st_in;
  logic [CW-1:0] cnt_in;
  logic [DW-1:0] wr_data;
  logic          wr_valid, wr_ready, busy, done, timed_out, seq_error;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          bus_we, bus_re;

  flash_bufprog_seq #(
    .AW(AW), .DW(DW), .BLK_BITS(BB), .CNT_W(CW), .WE_SETUP(1), .WE_WIDTH(WEW),
    .WE_HOLD(1), .RD_LAT(2), .TMO_CYCLES(TMO)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .block_addr(blk_in),
    .start_addr(st_in), .word_count(cnt_in), .wr_data(wr_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .busy(busy), .done(done),
    .timed_out(timed_out), .seq_error(seq_error), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata)
  );

  int checks = 0;
  int errors = 0;

  int run_id = 0;
  int avail_after = 0;
  int busy_reads = 0;
  int gap_mod = 0;
  bit stream_on = 0;
  int cons_base = 0;
  int consumed = 0;
  int cyc = 0;

  int            seen_id = 0;
  int            mode = 0;
  int            xsr_seen = 0;
  int            sr_seen = 0;
  int            log_n = 0;
  logic [AW-1:0] log_a [LOGN];
  logic [DW-1:0] log_d [LOGN];
  logic          we_prev = 1'b0;
  logic          re_prev = 1'b0;
  int            we_w = 0;
  logic [AW-1:0] we_a;
  logic [DW-1:0] we_dv;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always_comb begin
    bus_rdata = '0;
    if (mode == 1)      bus_rdata[7] = (xsr_seen > avail_after);
    else if (mode == 2) bus_rdata[7] = (sr_seen > busy_reads);
  end

  assign wr_data = DW'(32'hA000 + (consumed - cons_base));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (wr_valid && wr_ready) consumed <= consumed + 1;
  end

  always @(negedge clk) begin
    if (run_id != seen_id) begin
      seen_id  = run_id;
      mode     = 0;
      xsr_seen = 0;
      sr_seen  = 0;
      log_n    = 0;
    end
    if (bus_we && !we_prev) begin
      if (log_n < LOGN) begin
        log_a[log_n] = bus_addr;
        log_d[log_n] = bus_wdata;
      end
      log_n++;
      we_w  = 1;
      we_a  = bus_addr;
      we_dv = bus_wdata;
      if (bus_wdata[7:0] == 8'hE8)      mode = 1;
      else if (bus_wdata[7:0] == 8'hD0) mode = 2;
      else if (bus_wdata[7:0] == 8'hFF) mode = 0;
    end else if (bus_we) begin
      we_w++;
      if (bus_addr != we_a || bus_wdata != we_dv)
        chk(1'b0, "R9", "write address/data moved during strobe", bus_addr, we_a);
    end
    if (!bus_we && we_prev)
      chk(we_w == WEW, "R9", "write strobe width", we_w, WEW);
    if (bus_re && !re_prev) begin
      if (mode == 1)      xsr_seen++;
      else if (mode == 2) sr_seen++;
    end
    if (bus_we && bus_re) chk(1'b0, "R9", "write and read strobe together", 1, 0);
    we_prev  = bus_we;
    re_prev  = bus_re;
    wr_valid = stream_on && (gap_mod == 0 || (cyc % gap_mod) != 0);
  end

  task automatic expect_wr(inout int idx, input int ea, input int ed, input string tag);
    if (idx < LOGN && idx < log_n)
      chk(log_a[idx] == AW'(ea) && log_d[idx] == DW'(ed), tag,
          $sformatf("write #%0d addr/data", idx),
          {log_a[idx], log_d[idx]}, {AW'(ea), DW'(ed)});
    else
      chk(1'b0, tag, $sformatf("write #%0d missing", idx), log_n, idx + 1);
    idx++;
  endtask

  task automatic run_case(input int b, input int s, input int n, input int aa,
                          input int br, input int gm, input bit inject);
    int k, m, idx;
    bit tmo_exp;
    @(negedge clk);
    blk_in      = AW'(b);
    st_in       = AW'(s);
    cnt_in      = CW'(n);
    avail_after = aa;
    busy_reads  = br;
    gap_mod     = gm;
    cons_base   = consumed;
    stream_on   = 1'b1;
    run_id++;
    @(negedge clk);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10", "busy after start", busy, 1);
    if (inject) begin
      repeat (15) @(negedge clk);
      blk_in = AW'(b ^ 12'h400);
      st_in  = AW'(s + 3);
      cnt_in = CW'(n + 1);
      start  = 1'b1;
      @(negedge clk);
      start  = 1'b0;
    end
    k = 0;
    while (!done && k < 20000) begin
      @(negedge clk);
      k++;
    end
    if (!done) chk(1'b0, "R10", "watchdog: no done", 0, 1);
    m = 0;
    while (m <= n && ((s + m) >> BB) == (b >> BB) && (s + m) < (1 << AW)) m++;
    tmo_exp = (aa >= 1000);
    idx = 0;
    if (tmo_exp) begin
      chk(log_n >= 2, "R3", "writes before time-out", log_n, 2);
      for (int j = 0; j < log_n - 1 && j < LOGN; j++) expect_wr(idx, b, 'hE8, "R3");
      expect_wr(idx, b, 'hFF, "R3");
      chk(timed_out == 1'b1 && seq_error == 1'b0, "R3", "flags at done",
          {timed_out, seq_error}, 2'b10);
      chk(consumed - cons_base == 0, "R5", "stream words taken", consumed - cons_base, 0);
    end else begin
      for (int j = 0; j <= aa; j++) expect_wr(idx, b, 'hE8, "R2");
      expect_wr(idx, b, n, "R4");
      for (int j = 0; j < m; j++) expect_wr(idx, s + j, 'hA000 + j, "R5");
      if (m == n + 1) begin
        expect_wr(idx, b, 'hD0, "R6");
        expect_wr(idx, b, 'hFF, "R7");
        chk(timed_out == 1'b0 && seq_error == 1'b0, "R7", "flags at done",
            {timed_out, seq_error}, 2'b00);
      end else begin
        expect_wr(idx, b, 'h50, "R8");
        expect_wr(idx, b, 'hFF, "R8");
        chk(timed_out == 1'b0 && seq_error == 1'b1, "R8", "flags at done",
            {timed_out, seq_error}, 2'b01);
      end
      chk(log_n == idx, "R5", "total write count", log_n, idx);
      chk(consumed - cons_base == m, "R5", "stream words taken", consumed - cons_base, m);
      if (!tmo_exp) chk(sr_seen == ((m == n + 1) ? br + 1 : 0), "R7",
                        "status reads after confirm", sr_seen, (m == n + 1) ? br + 1 : 0);
    end
    stream_on = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R10", "done one cycle, idle after",
        {done, busy}, 2'b00);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n  = 1'b0;
    start  = 1'b0;
    blk_in = '0;
    st_in  = '0;
    cnt_in = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done in reset", {busy, done}, 0);
    chk(bus_we == 1'b0 && bus_re == 1'b0, "R1", "strobes in reset", {bus_we, bus_re}, 0);
    chk(wr_ready == 1'b0, "R1", "wr_ready in reset", wr_ready, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R1", "idle after reset", busy, 0);

    for (int n = 0; n < 32; n++)
      run_case('h040, 'h040, n, n % 3, n % 4, (n % 3 == 0) ? 0 : (n % 3) + 1, n == 7);
    for (int off = 1; off < 32; off += 3)
      run_case('h0C0, 'h0C0 + off, 31, 1, 1, 2, 1'b0);
    run_case('h0C5, 'h0C0, 5, 0, 2, 0, 1'b0);
    run_case('h0C0, 'h200, 4, 0, 0, 0, 1'b0);
    run_case('h0DF, 'h0DF, 3, 2, 0, 3, 1'b0);
    run_case('h040, 'h040, 3, 1000, 0, 0, 1'b0);
    run_case('h060, 'h060, 2, 0, 0, 0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule